// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address. The segment is shifted left by four bits, so every segment starts on a 16-byte paragraph boundary. The offset is then added to it. Any carry out of the top address bit is dropped, so addresses wrap modulo 1 MiB. As a result, many segment:offset pairs can name the same byte.

The block holds six 16-bit segment registers: code, data, stack, extra, and two more extra registers. Each requester states its kind: instruction fetch, stack access, data access or destination access. The kind picks a default register to pair with the offset. An explicit override can pick any of the six registers instead. Registers are loaded through a write port. The code register, and a broadcast that loads all six registers at once for flat-model setup, are accepted only together with the far-transfer strobe. The physical address is computed combinationally from the register contents as they stand. A write takes effect at the next clock edge.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals (selected segment × 16 + `offset`) modulo 2^20. A carry out of bit 19 is discarded.
- R2: Segment:offset pairs 0000:0029, 0001:0019 and 0002:0009 all yield physical address 00029h.
- R3: Bits [3:0] of `phys_addr` always equal bits [3:0] of `offset`, because a segment base has four zero low bits.
- R4: With `ovr_en` low, the register is chosen from `req_kind`:
  - 0 (fetch) selects the code register.
  - 1 (stack) selects the stack register.
  - 2 (data) selects the data register.
  - 3 (destination) selects the extra register.
- R5: With `ovr_en` high, `ovr_sel` picks the register directly:
  - 0 is code, 1 is data, 2 is stack, 3 is extra, 4 is the second extra register and 5 is the third extra register.
  - Values 6 and 7 fall back to the default pairing of R4.
  - `sel_seg` always shows the register that was chosen.
- R6: A write with `wr_sel` 1..5 (same codes as R5) loads `wr_data` at the next clock edge, whatever the value of `far_strobe`. In the cycle of the write, the address is still formed from the old value.
- R7: A write with `wr_sel` 0 (code) loads only when `far_strobe` is high. Without the strobe the write is ignored and `wr_err` is high for the following cycle only.
- R8: A write with `wr_sel` 7 and `far_strobe` high loads `wr_data` into all six registers at once. Without the strobe it is ignored and raises `wr_err` for one cycle.
- R9: Reset (`rst_n` low) clears all six registers to 0000h and clears `wr_err`.
- R10: A write with `wr_sel` 6 changes no register and raises `wr_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Segment register write request |
| wr_sel | input | 3 | Write target (0..5 register, 6 reserved, 7 all) |
| wr_data | input | 16 | Value to load |
| far_strobe | input | 1 | Far-transfer/system strobe that allows code and broadcast loads |
| req_kind | input | 2 | Requester kind that picks the default register |
| ovr_en | input | 1 | Use `ovr_sel` instead of the default register |
| ovr_sel | input | 3 | Explicit register choice |
| offset | input | 16 | Offset from the requester |
| phys_addr | output | 20 | Physical byte address |
| sel_seg | output | 16 | Value of the selected segment register |
| wr_err | output | 1 | One-cycle flag for a refused write |

## Verification
A register write and an address computation can fall in the same cycle, including the case where both target the same register. The bench provokes this by writing the data register while a data request is presented. It expects the address formed from the old value in that cycle and the new value in the next cycle. It also pairs a refused code write with a fetch in the following cycle. There the error flag must rise while the fetch address still shows the unchanged code register.

// File: rtl/segagen_pkg.sv
package segagen_pkg;

    typedef enum logic [2:0] {
        SEG_CODE  = 3'd0,
        SEG_DATA  = 3'd1,
        SEG_STACK = 3'd2,
        SEG_EXTRA = 3'd3,
        SEG_XF    = 3'd4,
        SEG_XG    = 3'd5,
        SEG_RSVD  = 3'd6,
        SEG_ALL   = 3'd7
    } seg_id_e;

    typedef enum logic [1:0] {
        REQ_FETCH = 2'd0,
        REQ_STACK = 2'd1,
        REQ_DATA  = 2'd2,
        REQ_DEST  = 2'd3
    } req_kind_e;

    localparam int unsigned SEG_COUNT = 6;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import segagen_pkg::*;
#(
    parameter int unsigned SEG_W   = 16,
    parameter int unsigned NUM_SEG = SEG_COUNT
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [2:0]                      wr_sel,
    input  logic [SEG_W-1:0]                wr_data,
    input  logic                            far_strobe,
    output logic [NUM_SEG-1:0][SEG_W-1:0]   seg_vals,
    output logic                            wr_err
);

    typedef struct packed {
        logic [NUM_SEG-1:0][SEG_W-1:0] seg;
        logic                          err;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr_en) begin
            if (wr_sel == SEG_ALL) begin
                if (far_strobe) begin
                    for (int i = 0; i < NUM_SEG; i++) st_d.seg[i] = wr_data;
                end else begin
                    st_d.err = 1'b1;
                end
            end else if (wr_sel == SEG_CODE) begin
                if (far_strobe) st_d.seg[0] = wr_data;
                else            st_d.err    = 1'b1;
            end else if (wr_sel == SEG_RSVD) begin
                st_d.err = 1'b1;
            end else begin
                for (int i = 1; i < NUM_SEG; i++) begin
                    if (wr_sel == 3'(i)) st_d.seg[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seg_vals = st_q.seg;
    assign wr_err   = st_q.err;

    assert_cs_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEG_CODE && !far_strobe)
        |=> (seg_vals[0] == $past(seg_vals[0]) && wr_err));

    assert_rsvd_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEG_RSVD) |=> (wr_err && $stable(seg_vals)));

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_err);

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_chk
        assert_bcast_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEG_ALL && far_strobe)
            |=> (seg_vals[g] == $past(wr_data)));
        if (g > 0) begin : g_plain
            assert_plain_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_sel == 3'(g)) |=> (seg_vals[g] == $past(wr_data)));
        end
    end

endmodule

// File: rtl/seg_select.sv
module seg_select
    import segagen_pkg::*;
#(
    parameter int unsigned SEG_W   = 16,
    parameter int unsigned NUM_SEG = SEG_COUNT
) (
    input  logic [NUM_SEG-1:0][SEG_W-1:0] seg_vals,
    input  logic [1:0]                    req_kind,
    input  logic                          ovr_en,
    input  logic [2:0]                    ovr_sel,
    output logic [SEG_W-1:0]              sel_seg
);

    logic [2:0] dflt_id;
    logic [2:0] pick_id;

    always_comb begin
        case (req_kind)
            REQ_FETCH: dflt_id = SEG_CODE;
            REQ_STACK: dflt_id = SEG_STACK;
            REQ_DATA:  dflt_id = SEG_DATA;
            default:   dflt_id = SEG_EXTRA;
        endcase
        if (ovr_en && (ovr_sel < 3'(NUM_SEG))) pick_id = ovr_sel;
        else                                   pick_id = dflt_id;
    end

    always_comb begin
        sel_seg = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (pick_id == 3'(i)) sel_seg = seg_vals[i];
        end
    end

endmodule

// File: rtl/addr_former.sv
module addr_former #(
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned SHIFT  = 4,
    parameter int unsigned ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] phys_addr
);

    localparam int unsigned BASE_W = SEG_W + SHIFT;

    logic [BASE_W-1:0] base;

    always_comb begin
        base      = {seg, {SHIFT{1'b0}}};
        phys_addr = ADDR_W'(base) + ADDR_W'(offset);
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import segagen_pkg::*;
#(
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned SHIFT  = 4,
    parameter int unsigned ADDR_W = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic              far_strobe,
    input  logic [1:0]        req_kind,
    input  logic              ovr_en,
    input  logic [2:0]        ovr_sel,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [SEG_W-1:0]  sel_seg,
    output logic              wr_err
);

    localparam int unsigned NUM_SEG = SEG_COUNT;

    logic [NUM_SEG-1:0][SEG_W-1:0] seg_vals;

    seg_regfile #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .far_strobe (far_strobe),
        .seg_vals   (seg_vals),
        .wr_err     (wr_err)
    );

    seg_select #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_sel (
        .seg_vals (seg_vals),
        .req_kind (req_kind),
        .ovr_en   (ovr_en),
        .ovr_sel  (ovr_sel),
        .sel_seg  (sel_seg)
    );

    addr_former #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_add (
        .seg       (sel_seg),
        .offset    (offset),
        .phys_addr (phys_addr)
    );

    assert_low_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[SHIFT-1:0] == offset[SHIFT-1:0]);

    assert_fetch_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_en && req_kind == REQ_FETCH) |-> (sel_seg == seg_vals[0]));

endmodule

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, far_strobe, ovr_en, wr_err;
    logic [2:0]  wr_sel, ovr_sel;
    logic [15:0] wr_data, offset, sel_seg;
    logic [1:0]  req_kind;
    logic [19:0] phys_addr;

    always #4 clk = ~clk;

    seg_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .far_strobe(far_strobe), .req_kind(req_kind), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .offset(offset), .phys_addr(phys_addr), .sel_seg(sel_seg), .wr_err(wr_err)
    );

    typedef struct {
        logic [19:0] addr;
        logic [15:0] seg;
        logic        err;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          tests  = 0;
    int          failed = 0;
    logic [15:0] m[6];
    logic        prev_err;
    bit          done = 0;

    function automatic logic [19:0] calc(input logic [15:0] s, input logic [15:0] o);
        logic [20:0] full;
        full = {1'b0, s, 4'b0} + {5'b0, o};
        return full[19:0];
    endfunction

    task automatic step(input logic we, input logic [2:0] ws, input logic [15:0] wd,
                        input logic fs, input logic [1:0] kind, input logic oe,
                        input logic [2:0] os, input logic [15:0] off, input string tag);
        int   idx;
        exp_t e;
        logic bad;
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_data = wd; far_strobe = fs;
        req_kind = kind; ovr_en = oe; ovr_sel = os; offset = off;
        if (oe && os < 3'd6) idx = int'(os);
        else case (kind)
            2'd0: idx = 0;
            2'd1: idx = 2;
            2'd2: idx = 1;
            default: idx = 3;
        endcase
        e.seg = m[idx]; e.addr = calc(m[idx], off); e.err = prev_err; e.tag = tag;
        sb_q.push_back(e);
        bad = 1'b0;
        if (we) begin
            if (ws == 3'd7) begin
                if (fs) for (int i = 0; i < 6; i++) m[i] = wd;
                else bad = 1'b1;
            end else if (ws == 3'd0) begin
                if (fs) m[0] = wd; else bad = 1'b1;
            end else if (ws == 3'd6) bad = 1'b1;
            else m[ws] = wd;
        end
        prev_err = bad;
    endtask

    // monitor: pops expected items and compares mid-cycle
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #3;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                tests++;
                if (phys_addr !== e.addr || sel_seg !== e.seg || wr_err !== e.err) begin
                    failed++;
                    $display("FAIL %s: addr=%h seg=%h err=%b expected addr=%h seg=%h err=%b",
                             e.tag, phys_addr, sel_seg, wr_err, e.addr, e.seg, e.err);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            failed++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) m[i] = '0;
        prev_err = 1'b0;
        rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; far_strobe = 0;
        req_kind = 0; ovr_en = 0; ovr_sel = 0; offset = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R9 reset state
        step(0, 0, 0, 0, 2'd0, 0, 0, 16'h0000, "R9 fetch after reset");
        step(0, 0, 0, 0, 2'd2, 1, 3'd5, 16'h0123, "R9 third extra after reset");
        // R6 write and same-cycle use
        step(1, 3'd1, 16'h1234, 0, 2'd2, 0, 0, 16'h0010, "R6 same-cycle old value");
        step(0, 0, 0, 0, 2'd2, 0, 0, 16'h0005, "R6 new value visible");
        step(0, 0, 0, 0, 2'd2, 0, 0, 16'h000F, "R3 low nibble");
        // R2 aliasing
        step(1, 3'd1, 16'h0000, 1, 2'd0, 0, 0, 0, "R6 far strobe irrelevant");
        step(1, 3'd3, 16'h0001, 0, 2'd0, 0, 0, 0, "R6 load extra");
        step(1, 3'd4, 16'h0002, 0, 2'd2, 0, 0, 16'h0029, "R2 0000:0029");
        step(0, 0, 0, 0, 2'd3, 0, 0, 16'h0019, "R2 0001:0019");
        step(0, 0, 0, 0, 2'd0, 1, 3'd4, 16'h0009, "R2 0002:0009");
        // R1 wrap
        step(1, 3'd5, 16'hFFFF, 0, 2'd0, 0, 0, 0, "R6 load third extra");
        step(0, 0, 0, 0, 2'd0, 1, 3'd5, 16'h0010, "R1 wrap to zero");
        step(0, 0, 0, 0, 2'd0, 1, 3'd5, 16'hFFFF, "R1 wrap high");
        // R4 stack default, R5 fallback
        step(1, 3'd2, 16'h0400, 0, 2'd1, 0, 0, 16'h0008, "R4 stack before load");
        step(0, 0, 0, 0, 2'd1, 0, 0, 16'h0008, "R4 stack pairing");
        step(0, 0, 0, 0, 2'd1, 1, 3'd6, 16'h0001, "R5 override 6 falls back");
        step(0, 0, 0, 0, 2'd3, 1, 3'd7, 16'h0001, "R5 override 7 falls back");
        step(0, 0, 0, 0, 2'd3, 1, 3'd2, 16'h0002, "R5 override stack");
        // R7 code protection
        step(1, 3'd0, 16'hABCD, 0, 2'd0, 0, 0, 16'h0002, "R7 refused code write");
        step(0, 0, 0, 0, 2'd0, 0, 0, 16'h0002, "R7 code unchanged, err");
        step(0, 0, 0, 0, 2'd0, 0, 0, 16'h0002, "R7 err one cycle");
        step(1, 3'd0, 16'hABCD, 1, 2'd0, 0, 0, 16'h0002, "R7 far code write");
        step(0, 0, 0, 0, 2'd0, 0, 0, 16'h0002, "R7 code loaded, no err");
        // R10 reserved
        step(1, 3'd6, 16'h5555, 1, 2'd2, 0, 0, 0, "R10 reserved write");
        step(0, 0, 0, 0, 2'd2, 0, 0, 0, "R10 nothing changed, err");
        // R8 broadcast
        step(1, 3'd7, 16'h0700, 0, 2'd0, 0, 0, 0, "R8 refused broadcast");
        step(0, 0, 0, 0, 2'd0, 0, 0, 0, "R8 unchanged, err");
        step(1, 3'd7, 16'h0700, 1, 2'd0, 0, 0, 0, "R8 far broadcast");
        for (int k = 0; k < 6; k++)
            step(0, 0, 0, 0, 2'd0, 1, 3'(k), 16'h0033, "R8 all equal after broadcast");
        step(0, 0, 0, 0, 2'd1, 0, 0, 16'hFFFF, "R8 flat span");
        repeat (3) @(negedge clk);
        done = 1;
        if (sb_q.size() != 0) begin
            failed++;
            tests++;
            $display("FAIL R1: %0d results missing, expected 0", sb_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule